// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block reads an 8 by 4 key matrix. It pulls one scan line low at a time, in a fixed rotation. While a line is low it samples four active-low return lines, which idle high through external pull-ups. After each full rotation (a sweep) it makes one key check. The result of a check is whether any key was seen down during that sweep, together with an OR-merge of the return lines and scan lines that were involved.

A debouncer watches the stream of checks. A press is accepted after three checks in a row report a key down. When a press is accepted the request output goes high, the key word is reset to its bare header, and scanning pauses until the host signals that it has finished reading. Scanning then resumes and the key word follows the live matrix. Three checks in a row with nothing pressed drop the request again. Power-down mode stops scanning and checking completely.

Top module: `key_matrix_scanner`

## Requirements
- R1: Out of reset, `key_req` is 0, `key_word` is 16'h1000 and every scan line is released (1).
- R2: While scanning, at most one scan line is low at a time. Lines go low in the order 0,1,...,7 and then wrap. Each line stays low for `SLOT_CYC` consecutive cycles. The return lines are sampled 3/4 of the way through that low period (after `SLOT_CYC*3/4` cycles of the slot).
- R3: One check is made per sweep. `key_req` rises only after three consecutive checks have seen at least one return line low. Two such checks do not raise it.
- R4: A check that sees no key down while `key_req` is low restarts the press count. Two pressed checks, then one empty check, then two more pressed checks do not raise `key_req`.
- R5: In the cycle `key_req` rises, `key_word` becomes 16'h1000. All scan lines are then released and `key_word` holds its value until `rd_done` is pulsed.
- R6: After `rd_done`, scanning restarts from line 0. Each check then loads `key_word` with 4'b0001 in bits 15:12, the return-line flags (bit 8+k for return k) in bits 11:8, and the scan-line flags (bit s for scan line s) in bits 7:0.
- R7: With several keys down, each return flag and each scan flag is the OR over all pressed keys. For example, keys (s2,k2) and (s2,k3) give 16'h1C04; (s2,k2) and (s4,k2) give 16'h1414.
- R8: While `key_req` is high, three consecutive checks with no key down drop it, and two do not. After the release, `key_word` reads 16'h1000.
- R9: While `pwr_down` is 1, all scan lines are released, no checks are made and `key_req` does not change.
- R10: An `rd_done` pulse while no request is waiting for a read has no effect: `key_req`, `key_word` and scanning continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | 1 stops scanning and checks |
| rd_done | input | 1 | One-cycle pulse: the host has finished reading `key_word` |
| ret_n | input | 4 | Return lines, active low, pulled up externally |
| scan_n | output | 8 | Scan lines, active low, open-drain style (1 = released) |
| key_req | output | 1 | Request to the host: a debounced press is held |
| key_word | output | 16 | Header, return flags and scan flags |

## Verification
The hardest situation to reach from the ports is a debounce count that sits exactly at a sweep boundary: two pressed checks followed by one empty check. The press and release instants therefore have to line up with the point where a sweep's sample lands. The bench locks onto the falling edge of scan line 0 and changes its matrix model a whole number of sweeps later. That lets it place presses that span exactly two or three checks, and a gap of exactly one check between them. The matrix model is driven by the scan outputs themselves, so the sampled returns always depend on which line is currently low.

// File: rtl/kmscan_pkg.sv
package kmscan_pkg;
  localparam int unsigned SCAN_LINES = 8;
  localparam int unsigned RET_LINES  = 4;
  localparam int unsigned DEB_DEPTH  = 3;
  localparam int unsigned HDR_W      = 4;
  localparam logic [HDR_W-1:0] WORD_HDR = 4'b0001;
endpackage

// File: rtl/kmscan_timer.sv
module kmscan_timer #(
  parameter int unsigned NS       = 8,
  parameter int unsigned SLOT_CYC = 8,
  localparam int unsigned SW      = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [NS-1:0] scan_n,
  output logic [SW-1:0] slot_idx,
  output logic          smp_stb,
  output logic          sweep_end
);
  localparam int unsigned CW        = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int unsigned SAMPLE_AT = (SLOT_CYC * 3) / 4;
  localparam int unsigned LAST      = SLOT_CYC - 1;

  logic [CW-1:0] cnt;
  logic [NS-1:0] line_sel;
  logic          slot_wrap;

  always_comb begin
    for (int i = 0; i < NS; i++) line_sel[i] = (slot_idx == SW'(i));
  end

  assign slot_wrap = (cnt == CW'(LAST));
  assign smp_stb   = run && (cnt == CW'(SAMPLE_AT));
  assign sweep_end = run && slot_wrap && (slot_idx == SW'(NS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      slot_idx <= '0;
      scan_n   <= '1;
    end else begin
      scan_n <= ~line_sel;
      if (slot_wrap) begin
        cnt      <= '0;
        slot_idx <= (slot_idx == SW'(NS - 1)) ? '0 : slot_idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kmscan_merge.sv
module kmscan_merge #(
  parameter int unsigned NS  = 8,
  parameter int unsigned NR  = 4,
  localparam int unsigned SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          smp_stb,
  input  logic          sweep_end,
  input  logic [SW-1:0] slot_idx,
  input  logic [NR-1:0] ret_n,
  input  logic [NS-1:0] scan_n,
  output logic          chk_valid,
  output logic          chk_any,
  output logic [NR-1:0] chk_cols,
  output logic [NS-1:0] chk_rows
);
  logic [NR-1:0] sync1, sync2;
  logic [NR-1:0] hit;
  logic [NR-1:0] acc_cols;
  logic [NS-1:0] acc_rows;

  assign hit = ~sync2;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '1;
      sync2 <= '1;
    end else begin
      sync1 <= ret_n;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      acc_cols  <= '0;
      acc_rows  <= '0;
      chk_valid <= 1'b0;
    end else begin
      chk_valid <= sweep_end;
      if (sweep_end) begin
        acc_cols <= '0;
        acc_rows <= '0;
      end else if (smp_stb) begin
        acc_cols           <= acc_cols | hit;
        acc_rows[slot_idx] <= acc_rows[slot_idx] | (|hit);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_any  <= 1'b0;
      chk_cols <= '0;
      chk_rows <= '0;
    end else if (run && sweep_end) begin
      chk_any  <= |acc_rows;
      chk_cols <= acc_cols;
      chk_rows <= acc_rows;
    end
  end

  // R2: a sample is only taken while exactly one scan line is pulled low
  assert_sample_in_slot_R2: assert property (@(posedge clk) disable iff (rst)
    smp_stb |-> ($countones(~scan_n) == 1));
endmodule

// File: rtl/kmscan_debounce.sv
module kmscan_debounce #(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic chk_valid,
  input  logic chk_any,
  output logic req,
  output logic accept
);
  logic [CW-1:0] cnt;
  logic          agree;
  logic          at_limit;

  assign agree    = chk_valid && (req ? !chk_any : chk_any);
  assign at_limit = (cnt == CW'(DEPTH - 1));
  assign accept   = agree && !req && at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      cnt <= '0;
    end else if (chk_valid) begin
      if (agree) begin
        if (at_limit) begin
          req <= ~req;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  assert_rise_on_press_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(chk_valid && chk_any));

  assert_fall_on_release_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> $past(chk_valid && !chk_any));

  // R4: a disagreeing check never changes the request
  assert_no_flip_on_disagree_R4: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !agree) |=> $stable(req));
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner
  import kmscan_pkg::*;
#(
  parameter int unsigned SCAN_N     = SCAN_LINES,
  parameter int unsigned RET_N      = RET_LINES,
  parameter int unsigned SLOT_CYC   = 4440,
  parameter int unsigned DEB_CHECKS = DEB_DEPTH,
  localparam int unsigned WORD_W    = HDR_W + RET_N + SCAN_N,
  localparam int unsigned SW        = (SCAN_N > 1) ? $clog2(SCAN_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_down,
  input  logic              rd_done,
  input  logic [RET_N-1:0]  ret_n,
  output logic [SCAN_N-1:0] scan_n,
  output logic              key_req,
  output logic [WORD_W-1:0] key_word
);
  localparam logic [WORD_W-1:0] IDLE_WORD = {WORD_HDR, {(RET_N + SCAN_N){1'b0}}};

  logic              hold;
  logic              run;
  logic [SW-1:0]     slot_idx;
  logic              smp_stb, sweep_end;
  logic              chk_valid, chk_any, accept;
  logic [RET_N-1:0]  chk_cols;
  logic [SCAN_N-1:0] chk_rows;

  assign run = !pwr_down && !hold;

  kmscan_timer #(.NS(SCAN_N), .SLOT_CYC(SLOT_CYC)) timer_i (
    .clk(clk), .rst(rst), .run(run), .scan_n(scan_n),
    .slot_idx(slot_idx), .smp_stb(smp_stb), .sweep_end(sweep_end)
  );

  kmscan_merge #(.NS(SCAN_N), .NR(RET_N)) merge_i (
    .clk(clk), .rst(rst), .run(run), .smp_stb(smp_stb),
    .sweep_end(sweep_end), .slot_idx(slot_idx), .ret_n(ret_n),
    .scan_n(scan_n), .chk_valid(chk_valid), .chk_any(chk_any),
    .chk_cols(chk_cols), .chk_rows(chk_rows)
  );

  kmscan_debounce #(.DEPTH(DEB_CHECKS)) deb_i (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_any(chk_any),
    .req(key_req), .accept(accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= 1'b0;
      key_word <= IDLE_WORD;
    end else begin
      if (accept) begin
        hold     <= 1'b1;
        key_word <= IDLE_WORD;
      end else begin
        if (rd_done) hold <= 1'b0;
        if (chk_valid) key_word <= {WORD_HDR, chk_cols, chk_rows};
      end
    end
  end

  assert_header_on_req_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(key_req) |-> (key_word == IDLE_WORD));

  assert_frozen_until_read_R5: assert property (@(posedge clk) disable iff (rst)
    (hold && !rd_done) |=> ($stable(key_word) && (scan_n == '1)));

  assert_pd_released_R9: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (scan_n == '1));

  assert_pd_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && $past(pwr_down)) |=> $stable(key_req));
endmodule

// File: tb/key_matrix_scanner_tb_top.sv
module key_matrix_scanner_tb_top;
  localparam int unsigned SLOT  = 8;
  localparam int unsigned SWEEP = SLOT * 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_down = 1'b0;
  logic        rd_done = 1'b0;
  logic [3:0]  ret_n;
  logic [7:0]  scan_n;
  logic        key_req;
  logic [15:0] key_word;
  logic [31:0] keys = '0;   // bit s*4+k: key at scan s, return k held down

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  key_matrix_scanner #(.SLOT_CYC(SLOT)) dut_i (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .rd_done(rd_done),
    .ret_n(ret_n), .scan_n(scan_n), .key_req(key_req), .key_word(key_word)
  );

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      ret_n[k] = 1'b1;
      for (int s = 0; s < 8; s++)
        if (keys[s*4+k] && !scan_n[s]) ret_n[k] = 1'b0;
    end
  end

  function automatic logic [15:0] exp_word(input logic [31:0] m);
    logic [3:0] c = '0;
    logic [7:0] r = '0;
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++)
        if (m[s*4+k]) begin
          c[k] = 1'b1;
          r[s] = 1'b1;
        end
    return {4'b0001, c, r};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_sweep();
    logic p;
    p = scan_n[0];
    forever begin
      @(negedge clk);
      if (p === 1'b1 && scan_n[0] === 1'b0) break;
      p = scan_n[0];
    end
  endtask

  task automatic pulse_read();
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 req in reset", key_req, 0);
    chk("R1 word in reset", key_word, 16'h1000);
    chk("R1 scan in reset", scan_n, 8'hFF);
  endtask

  task automatic test_scan_order();
    int bad = 0;
    sync_sweep();
    for (int i = 0; i < SWEEP; i++) begin
      if (scan_n !== ~(8'h01 << (i / SLOT))) bad++;
      @(negedge clk);
    end
    chk("R2 scan order and slot length", bad, 0);
    chk("R2 wraps to line 0", scan_n, 8'hFE);
  endtask

  task automatic press_cycle(input string tag, input logic [31:0] m, input logic [15:0] exp);
    sync_sweep();
    keys = m;
    wait_n(2 * SWEEP + 32);
    chk({"R3 no req after two checks ", tag}, key_req, 0);
    wait_n(40);
    chk({"R3 req after three checks ", tag}, key_req, 1);
    chk({"R5 header on req ", tag}, key_word, 16'h1000);
    chk({"R5 scan paused ", tag}, scan_n, 8'hFF);
    wait_n(100);
    chk({"R5 still frozen ", tag}, {key_word, scan_n}, {16'h1000, 8'hFF});
    pulse_read();
    wait_n(100);
    chk({"R6 R7 merged word ", tag}, key_word, exp_word(m));
    chk({"R7 literal word ", tag}, key_word, exp);
    sync_sweep();
    keys = '0;
    wait_n(2 * SWEEP + 32);
    chk({"R8 req held after two empty checks ", tag}, key_req, 1);
    wait_n(40);
    chk({"R8 req dropped ", tag}, key_req, 0);
    chk({"R8 word after release ", tag}, key_word, 16'h1000);
  endtask

  task automatic test_short_press();
    sync_sweep();
    keys = 32'h1 << (3*4+1);
    wait_n(2 * SWEEP);
    keys = '0;
    wait_n(300);
    chk("R3 two checks do not raise req", key_req, 0);
  endtask

  task automatic test_count_restart();
    sync_sweep();
    keys = 32'h1 << (3*4+1);
    wait_n(2 * SWEEP);
    keys = '0;
    wait_n(SWEEP);
    keys = 32'h1 << (3*4+1);
    wait_n(2 * SWEEP);
    keys = '0;
    wait_n(200);
    chk("R4 empty check restarts count", key_req, 0);
  endtask

  task automatic test_power_down();
    pwr_down = 1'b1;
    keys = 32'h1 << (5*4+0);
    wait_n(2);
    chk("R9 scan released", scan_n, 8'hFF);
    wait_n(6 * SWEEP);
    chk("R9 no req while powered down", key_req, 0);
    chk("R9 still released", scan_n, 8'hFF);
    pwr_down = 1'b0;
    wait_n(3 * SWEEP + 40);
    chk("R9 scanning resumes after power down", key_req, 1);
    pulse_read();
    keys = '0;
    wait_n(4 * SWEEP);
    chk("R9 cleanup release", key_req, 0);
  endtask

  task automatic test_stray_read();
    int lows = 0;
    pulse_read();
    wait_n(2);
    chk("R10 req unchanged", key_req, 0);
    chk("R10 word unchanged", key_word, 16'h1000);
    for (int i = 0; i < 20; i++) begin
      if (scan_n !== 8'hFF) lows++;
      @(negedge clk);
    end
    chk("R10 scanning continues", lows > 0, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst = 1'b0;
    wait_n(2);
    chk("R1 req after reset", key_req, 0);
    test_scan_order();
    test_stray_read();
    press_cycle("single", 32'h1 << (3*4+1), 16'h1208);
    press_cycle("same scan", (32'h1 << (2*4+2)) | (32'h1 << (2*4+3)), 16'h1C04);
    press_cycle("same return", (32'h1 << (2*4+2)) | (32'h1 << (4*4+2)), 16'h1414);
    press_cycle("corners", (32'h1 << (0*4+0)) | (32'h1 << (7*4+3)), 16'h1981);
    test_short_press();
    test_count_restart();
    test_power_down();
    finish_run();
  end
endmodule